// File: doc/BRIEF.md
# Address-Event Synaptic Routing Engine

This block turns spike events, each given as a neuron address, into a series of synapse events for a neuron array. It uses the spike address to find a fan-out list in an external synchronous table RAM. Every word in that list names one postsynaptic target. The word also gives the target a potential-size code, an 8-bit driving level for a DAC, a repeat count and a transmission probability. Each candidate event passes through a pseudo-random gate and, if it passes, is issued on a valid/ready event port. Events leave one at a time.

Spikes that the neuron array fires back enter a small queue. Queued spikes are looked up before any new external spike is accepted. The first word of the looked-up list carries a mode bit. When the bit is set, the returned spike fans out again (recurrent loop). When it is clear, the spike address is forwarded on an external output port instead (feed-forward).

Top module: `syn_router`

## Requirements
- R1: After reset, ev_valid, out_valid and ram_rd are low, and both in_ready and sp_ready are high.
- R2: A spike at address A reads table words A*4, A*4+1, ... in order, one per ram_rd pulse. The data is taken one cycle after the pulse, and no event or forward appears in that cycle.
- R3: Table word layout: [3:0] target, [5:4] potential size, [7:6] repeat field N, [11:8] probability P, [19:12] driving level, [20] mode, [21] last. Each word yields N+1 candidate events carrying its target, size and driving level.
- R4: A list ends after the word with bit 21 set, or after the fourth word of the slot when no word in the slot has that bit set.
- R5: A 16-bit shift register starts at 16'hACE1 and steps as l <= {l[14:0], l[15]^l[13]^l[12]^l[10]}. A candidate is issued only when l[3:0] < P, so P = 0 never sends. The register steps once per candidate, whether it is sent or dropped, and it holds while a sent candidate waits for ev_ready.
- R6: Only one event is offered at a time. While ev_ready is low, an offered event holds its target, size and driving level.
- R7: Array spikes enter a 4-entry queue. sp_ready is low while the queue holds 4 spikes.
- R8: Queued array spikes are served in arrival order before any external spike. in_ready is high only when the engine is idle and the queue is empty.
- R9: For an array spike whose first table word has mode bit 0, the engine emits no events and offers the spike address on out_addr until out_ready is high. With mode bit 1, the spike fans out as in R2 to R5.
- R10: External spikes always fan out, whatever the mode bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | External spike present |
| in_ready | output | 1 | External spike accepted |
| in_addr | input | 4 | External spike neuron address |
| sp_valid | input | 1 | Array spike present |
| sp_ready | output | 1 | Array spike queue has room |
| sp_addr | input | 4 | Array spike neuron address |
| ram_rd | output | 1 | Table read strobe |
| ram_addr | output | 6 | Table word address |
| ram_rdata | input | 22 | Table word, valid one cycle after ram_rd |
| ev_valid | output | 1 | Synapse event offered |
| ev_ready | input | 1 | Neuron array takes the event |
| ev_addr | output | 4 | Postsynaptic target |
| ev_psz | output | 2 | Potential-size code |
| ev_drv | output | 8 | DAC driving level |
| out_valid | output | 1 | Forwarded spike offered |
| out_ready | input | 1 | Forwarded spike taken |
| out_addr | output | 4 | Forwarded spike address |

## Verification
The bench builds the block with its defaults: 16 neurons, a stride of 4 words and a 4-entry queue. This gives a 64-word table that the bench fills entirely, so random spikes reach every list slot. Four stalled pushes fill the queue. The 4-bit probability lets the bench place P = 0 and P = 15 lists next to random ones. Because the shift register is only 16 bits, the bench can follow its exact value across every candidate, so each issued or dropped event is predicted word by word.

// File: rtl/syn_router.sv
module syn_router #(
  parameter int AW        = 4,
  parameter int STRIDE_LG = 2,
  parameter int PW        = 2,
  parameter int CW        = 2,
  parameter int QW        = 4,
  parameter int DW        = 8,
  parameter int FIFO_LG   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [AW-1:0]        in_addr,
  input  logic                 sp_valid,
  output logic                 sp_ready,
  input  logic [AW-1:0]        sp_addr,
  output logic                 ram_rd,
  output logic [AW+STRIDE_LG-1:0] ram_addr,
  input  logic [AW+PW+CW+QW+DW+1:0] ram_rdata,
  output logic                 ev_valid,
  input  logic                 ev_ready,
  output logic [AW-1:0]        ev_addr,
  output logic [PW-1:0]        ev_psz,
  output logic [DW-1:0]        ev_drv,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [AW-1:0]        out_addr
);
  localparam int F_PSZ  = AW;
  localparam int F_CNT  = F_PSZ + PW;
  localparam int F_PRB  = F_CNT + CW;
  localparam int F_DRV  = F_PRB + QW;
  localparam int F_MODE = F_DRV + DW;
  localparam int F_LAST = F_MODE + 1;
  localparam int WW     = F_LAST + 1;
  localparam int DEPTH  = 1 << FIFO_LG;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WT, S_EV, S_FWD} st_t;
  st_t st;

  logic [AW-1:0]        cur;
  logic                 arr;
  logic [STRIDE_LG-1:0] off;
  logic [WW-1:0]        wreg;
  logic [CW-1:0]        rep;
  logic [15:0]          lfsr;
  logic [AW-1:0]        fq [DEPTH];
  logic [FIFO_LG-1:0]   wp, rp;
  logic [FIFO_LG:0]     fcnt;

  wire gate  = lfsr[QW-1:0] < wreg[F_PRB +: QW];
  wire step  = (st == S_EV) && (!gate || ev_ready);
  wire empty = (fcnt == 0);
  wire pop   = (st == S_IDLE) && !empty;
  wire push  = sp_valid && sp_ready;

  assign sp_ready  = (fcnt != DEPTH[FIFO_LG:0]);
  assign in_ready  = (st == S_IDLE) && empty;
  assign ram_rd    = (st == S_RD);
  assign ram_addr  = {cur, off};
  assign ev_valid  = (st == S_EV) && gate;
  assign ev_addr   = wreg[AW-1:0];
  assign ev_psz    = wreg[F_PSZ +: PW];
  assign ev_drv    = wreg[F_DRV +: DW];
  assign out_valid = (st == S_FWD);
  assign out_addr  = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) begin
        fq[wp] <= sp_addr;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      fcnt <= fcnt + {{FIFO_LG{1'b0}}, push} - {{FIFO_LG{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else if (step) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; arr <= 1'b0; off <= '0; wreg <= '0; rep <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          off <= '0;
          if (pop) begin
            cur <= fq[rp]; arr <= 1'b1; st <= S_RD;
          end else if (in_valid) begin
            cur <= in_addr; arr <= 1'b0; st <= S_RD;
          end
        end
        S_RD: st <= S_WT;
        S_WT: begin
          wreg <= ram_rdata;
          rep  <= ram_rdata[F_CNT +: CW];
          st   <= (arr && off == '0 && !ram_rdata[F_MODE]) ? S_FWD : S_EV;
        end
        S_EV: if (step) begin
          if (rep == '0) begin
            if (wreg[F_LAST] || &off) st <= S_IDLE;
            else begin
              off <= off + 1'b1;
              st  <= S_RD;
            end
          end else rep <= rep - 1'b1;
        end
        S_FWD: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> !ram_rd && !ev_valid && !out_valid); // R2
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> $stable(lfsr)); // R5
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_addr) && $stable(ev_psz) && $stable(ev_drv)); // R6
  AST_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_valid, out_valid, ram_rd})); // R6
  AST_QUEUE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && (fcnt != 0) |=> arr && ram_rd); // R8
  AST_FWD_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> arr); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R9
endmodule

// File: tb/syn_router_test.sv
module syn_router_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, sp_valid = 0, ev_ready = 0, out_ready = 0;
  logic [3:0] in_addr = 0, sp_addr = 0;
  logic in_ready, sp_ready, ram_rd, ev_valid, out_valid;
  logic [5:0] ram_addr;
  logic [21:0] ram_rdata = '0;
  logic [3:0] ev_addr, out_addr;
  logic [1:0] ev_psz;
  logic [7:0] ev_drv;

  int nchk = 0, nfail = 0;
  bit stall = 0;
  logic [21:0] mem [64];
  logic [31:0] expq[$], obsq[$];
  logic [15:0] ml = 16'hACE1;

  always #10 clk = ~clk;

  syn_router uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .sp_valid(sp_valid), .sp_ready(sp_ready), .sp_addr(sp_addr), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_psz(ev_psz),
    .ev_drv(ev_drv), .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr));

  always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

  function automatic logic [31:0] rec(input bit k, input logic [3:0] a, input logic [1:0] p, input logic [7:0] d);
    return {7'd0, k, 4'd0, a, 6'd0, p, d};
  endfunction

  function automatic logic [15:0] lf_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected behaviour of one served spike (R2 R3 R4 R5 R9 R10)
  task automatic model_job(input logic [3:0] a, input bit from_arr);
    logic [21:0] w;
    w = mem[{a, 2'd0}];
    if (from_arr && !w[20]) begin
      expq.push_back(rec(1, a, 0, 0));
      return;
    end
    for (int i = 0; i < 4; i++) begin
      w = mem[{a, 2'(i)}];
      for (int k = 0; k <= int'(w[7:6]); k++) begin
        if (ml[3:0] < w[11:8]) expq.push_back(rec(0, w[3:0], w[5:4], w[19:12]));
        ml = lf_next(ml);
      end
      if (w[21]) break;
    end
  endtask

  // handshake monitor and ready driver; also checks R6 hold
  initial begin
    bit pend = 0;
    logic [31:0] held = 0;
    forever begin
      @(negedge clk);
      ev_ready  = stall ? 1'b0 : ($urandom % 4 != 0);
      out_ready = ($urandom % 3 != 0);
      #8;
      if (pend) chk(ev_valid && rec(0, ev_addr, ev_psz, ev_drv) == held, "R6 stalled event held",
                    rec(0, ev_addr, ev_psz, ev_drv), held);
      pend = ev_valid && !ev_ready;
      held = rec(0, ev_addr, ev_psz, ev_drv);
      if (ev_valid && ev_ready) obsq.push_back(rec(0, ev_addr, ev_psz, ev_drv));
      if (out_valid && out_ready) obsq.push_back(rec(1, out_addr, 0, 0));
    end
  end

  task automatic send_in(input logic [3:0] a);
    bit hs;
    @(negedge clk); in_valid = 1; in_addr = a;
    do begin #8; hs = in_ready; @(negedge clk); end while (!hs);
    in_valid = 0;
  endtask

  task automatic send_sp(input logic [3:0] a);
    bit hs;
    @(negedge clk); sp_valid = 1; sp_addr = a;
    do begin #8; hs = sp_ready; @(negedge clk); end while (!hs);
    sp_valid = 0;
  endtask

  task automatic wait_done();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk); #8;
      if (obsq.size() >= expq.size() && in_ready && !ev_valid && !out_valid) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic compare(input string tag);
    chk(obsq.size() == expq.size(), {tag, " R2 R3 R5 record count"}, obsq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < obsq.size(); i++)
      chk(obsq[i] == expq[i], {tag, " R3 R5 R8 R9 record"}, obsq[i], expq[i]);
    expq.delete(); obsq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 22'($urandom);
      mem[i][21] = (i % 4 == 3) || ($urandom % 3 == 0);
    end
    for (int i = 0; i < 4; i++) begin
      mem[4 + i][11:8]  = 4'd0;                    // R5 never-send list
      mem[4 + i][21]    = (i == 3);
      mem[12 + i][21]   = 1'b0;                    // R4 end at slot boundary
      mem[20 + i][11:8] = 4'd15;                   // busy list for stalls
      mem[20 + i][7:6]  = 2'd3;
      mem[20 + i][21]   = (i == 3);
    end
    mem[8][20] = 1'b0;                             // R9 forward, R10 for external

    repeat (3) @(negedge clk);
    #8;
    chk(!ev_valid && !out_valid && !ram_rd, "R1 outputs idle", {ev_valid, out_valid, ram_rd}, 0);
    chk(in_ready && sp_ready, "R1 ready high", {in_ready, sp_ready}, 2'b11);
    @(negedge clk); rst_n = 1;

    model_job(1, 0); send_in(1); wait_done(); compare("R5 P=0");
    model_job(2, 0); send_in(2); wait_done(); compare("R10 ext ignores mode");
    model_job(3, 0); send_in(3); wait_done(); compare("R4 slot end");
    model_job(2, 1); send_sp(2); wait_done(); compare("R9 forward");

    // R7 R8: fill queue while events stall, then check priority
    stall = 1;
    send_in(5);
    do begin @(negedge clk); #8; end while (!ev_valid);
    send_sp(2); send_sp(6); send_sp(7); send_sp(9);
    #8;
    chk(!sp_ready, "R7 full queue back-pressure", sp_ready, 0);
    chk(!in_ready, "R8 input blocked while busy", in_ready, 0);
    model_job(5, 0); model_job(2, 1); model_job(6, 1); model_job(7, 1); model_job(9, 1); model_job(4, 0);
    fork send_in(4); join_none
    repeat (3) @(negedge clk);
    stall = 0;
    wait_done(); compare("R7 R8 priority");

    for (int n = 0; n < 40; n++) begin
      logic [3:0] a;
      a = 4'($urandom);
      if ($urandom % 2) begin model_job(a, 1); send_sp(a); end
      else begin model_job(a, 0); send_in(a); end
      wait_done(); compare("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule